// File: doc/BRIEF.md
# Lockable Double-Buffered PWM Generator

A single-channel pulse-width timer driven by a small memory-mapped register port. Software programs a period and a duty count, both in clock cycles, and a control word that enables the channel, picks the output level used during the duty phase and the level used while idle, and holds a lock bit. The waveform is left-aligned: each period starts with the duty phase.

Every period or duty write goes first into a shadow copy. The running copy, together with both level bits, is refreshed only at a period boundary, so the output never shows a cut-short or stretched period. While the lock bit is set, nothing is refreshed. Software can stage a full new setting, including polarity, and clear the lock to make all of it take effect together at the next period start. While the channel is stopped, the running copy follows the shadow copy on every cycle, so the first period after enable uses the current settings.

Top module: `pwm_lockable_top`

## Requirements
- R1: After reset, the counter, period, duty and control registers all read 0, and `pwm_o` is 0.
- R2: Register byte offsets: counter 0x00, period 0x04, duty 0x08, control 0x0C. Control bits: 0 enable, 1 continuous, 3 duty-phase level, 4 idle level, 6 lock. All other control bits read 0.
- R3: The channel runs only when control bits 0 and 1 are both 1. Otherwise the counter reads 0 and `pwm_o` drives the idle level.
- R4: While running, the counter steps 0,1,…,P−1 and then returns to 0, where P is the active period. It is readable at offset 0x00, and writes to that offset have no effect.
- R5: Left alignment: for the first D cycles of each period (D = active duty) `pwm_o` is at the duty-phase level, and for the rest of the period it is at the idle level.
- R6: If D ≥ P, the whole period is at the duty-phase level. If D = 0, the whole period is at the idle level.
- R7: Bit 3 = 1 gives a high duty phase and 0 a low one. Bit 4 = 1 gives a high idle level and 0 a low one.
- R8: With lock at 0, a period or duty write made during a period does not change that period; it takes effect from the next period start.
- R9: While lock is 1, period/duty writes and level-bit changes do not alter the running waveform or its period length.
- R10: After lock is cleared, the staged period, duty and both level bits take effect together at the next period start.
- R11: Reads of period and duty return the last value written, whether or not that value is active yet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr_i | input | 4 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| pwm_o | output | 1 | PWM output |

## Verification
A wrong commit condition shows up within one period. Either the high-cycle count of the period in which a write landed differs from the old duty, or the counter's wrap point moves while the lock is held. A stale or frozen active copy keeps the previous high count or polarity past the first period start after unlock. A miswired level bit shows up at once as the wrong idle level while the channel is stopped. An off-by-one in the wrap compare makes the counter readback sequence one value long or short within a single period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_CNT  = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_PER  = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_DUTY = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'hC;

  localparam int unsigned BIT_EN      = 0;
  localparam int unsigned BIT_CONT    = 1;
  localparam int unsigned BIT_DUTY_HI = 3;
  localparam int unsigned BIT_IDLE_HI = 4;
  localparam int unsigned BIT_LOCK    = 6;

  typedef struct packed {
    logic lock;
    logic idle_hi;
    logic duty_hi;
    logic cont;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] cnt_i,
  output logic [DW-1:0] rdata_o,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] per_sh_o,
  output logic [DW-1:0] duty_sh_o
);
  logic [DW-1:0] ctrl_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      per_sh_o  <= '0;
      duty_sh_o <= '0;
    end else if (we_i) begin
      if (addr_i == OFF_PER)  per_sh_o  <= wdata_i;
      if (addr_i == OFF_DUTY) duty_sh_o <= wdata_i;
      if (addr_i == OFF_CTRL) begin
        ctrl_o.en      <= wdata_i[BIT_EN];
        ctrl_o.cont    <= wdata_i[BIT_CONT];
        ctrl_o.duty_hi <= wdata_i[BIT_DUTY_HI];
        ctrl_o.idle_hi <= wdata_i[BIT_IDLE_HI];
        ctrl_o.lock    <= wdata_i[BIT_LOCK];
      end
    end
  end

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[BIT_EN]      = ctrl_o.en;
    ctrl_word[BIT_CONT]    = ctrl_o.cont;
    ctrl_word[BIT_DUTY_HI] = ctrl_o.duty_hi;
    ctrl_word[BIT_IDLE_HI] = ctrl_o.idle_hi;
    ctrl_word[BIT_LOCK]    = ctrl_o.lock;
  end

  always_comb begin
    unique case (addr_i)
      OFF_CNT:  rdata_o = cnt_i;
      OFF_PER:  rdata_o = per_sh_o;
      OFF_DUTY: rdata_o = duty_sh_o;
      OFF_CTRL: rdata_o = ctrl_word;
      default:  rdata_o = '0;
    endcase
  end

  AST_PER_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_PER) |=> per_sh_o == $past(wdata_i)); // R11
  AST_DUTY_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_DUTY) |=> duty_sh_o == $past(wdata_i)); // R11
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctrl_t         ctrl_i,
  input  logic [DW-1:0] per_sh_i,
  input  logic [DW-1:0] duty_sh_i,
  output logic [DW-1:0] cnt_o,
  output logic          pwm_o
);
  logic [DW-1:0] per_act, duty_act;
  logic          duty_hi_act, idle_hi_act;
  logic [DW:0]   cnt_inc;
  logic          running, wrap, commit;

  assign running = ctrl_i.en & ctrl_i.cont;
  assign cnt_inc = {1'b0, cnt_o} + 1'b1;
  assign wrap    = cnt_inc >= {1'b0, per_act};
  // stopped channel tracks shadow; running one refreshes only on wrap
  assign commit  = ~ctrl_i.lock & (~running | wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_act     <= '0;
      duty_act    <= '0;
      duty_hi_act <= 1'b0;
      idle_hi_act <= 1'b0;
      cnt_o       <= '0;
    end else begin
      if (commit) begin
        per_act     <= per_sh_i;
        duty_act    <= duty_sh_i;
        duty_hi_act <= ctrl_i.duty_hi;
        idle_hi_act <= ctrl_i.idle_hi;
      end
      if (!running || wrap) cnt_o <= '0;
      else                  cnt_o <= cnt_inc[DW-1:0];
    end
  end

  assign pwm_o = (running && cnt_o < duty_act) ? duty_hi_act : idle_hi_act;

  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.lock |=> $stable(per_act) && $stable(duty_act)
                    && $stable(duty_hi_act) && $stable(idle_hi_act)); // R9
  AST_NO_MIDPERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !wrap) |=> $stable(per_act) && $stable(duty_act)); // R8
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && per_act != '0) |-> cnt_o < per_act); // R4
  AST_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |=> cnt_o == '0); // R3
endmodule

// File: rtl/pwm_lockable_top.sv
module pwm_lockable_top
  import pwm_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          pwm_o
);
  ctrl_t         ctrl;
  logic [DW-1:0] per_sh, duty_sh, cnt;

  pwm_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .cnt_i     (cnt),
    .rdata_o   (bus_rdata_o),
    .ctrl_o    (ctrl),
    .per_sh_o  (per_sh),
    .duty_sh_o (duty_sh)
  );

  pwm_core #(.DW(DW)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl),
    .per_sh_i  (per_sh),
    .duty_sh_i (duty_sh),
    .cnt_o     (cnt),
    .pwm_o     (pwm_o)
  );
endmodule

// File: tb/tb_pwm_lockable_top.sv
`timescale 1ns/1ps
module tb_pwm_lockable_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  pwm_lockable_top dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = 4'h0; #1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = 4'h0; #1;
  endtask

  task automatic sync_start();
    logic [31:0] c;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1; rd(4'h0, c);
      if (c == 0) break;
    end
  endtask

  task automatic measure(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      highs += int'(pwm);
      @(negedge clk); #1;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), v);
      check(v == 0, "R1 reset read", v, 0);
    end
    check(pwm == 1'b0, "R1 reset pwm", pwm, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(4'h4, 10); wr(4'h8, 3);
    rd(4'h4, v); check(v == 10, "R2 R11 period readback", v, 10);
    rd(4'h8, v); check(v == 3, "R2 R11 duty readback", v, 3);
    wr(4'hC, 32'hFF);
    rd(4'hC, v); check(v == 32'h5B, "R2 ctrl bits", v, 32'h5B);
    wr(4'hC, 32'h10);
    repeat (2) @(negedge clk); #1;
    check(pwm == 1'b1, "R3 R7 idle high when off", pwm, 1);
    rd(4'h0, v); check(v == 0, "R3 counter zero when off", v, 0);
    wr(4'hC, 32'h09);
    repeat (3) @(negedge clk); #1;
    check(pwm == 1'b0, "R3 enable without continuous stays idle", pwm, 0);
    rd(4'h0, v); check(v == 0, "R3 counter held, enable only", v, 0);
    wr(4'hC, 32'h0A);
    repeat (3) @(negedge clk); #1;
    rd(4'h0, v); check(v == 0, "R3 counter held, continuous only", v, 0);
  endtask

  task automatic t_basic();
    int h;
    wr(4'hC, 32'h0B);
    sync_start(); measure(20, h); check(h == 6, "R5 highs over two periods", h, 6);
    sync_start(); measure(3, h);  check(h == 3, "R5 duty phase first", h, 3);
    measure(7, h);                check(h == 0, "R5 idle after duty", h, 0);
  endtask

  task automatic t_counter();
    logic [31:0] v;
    sync_start();
    for (int k = 0; k < 12; k++) begin
      rd(4'h0, v);
      check(v == 32'(k % 10), "R4 counter sequence", v, k % 10);
      @(negedge clk); #1;
    end
    rd(4'h0, v);
    wr(4'h0, 5);
    begin
      logic [31:0] w;
      rd(4'h0, w);
      check(w == (v + 2) % 10, "R4 counter write ignored", w, (v + 2) % 10);
    end
  endtask

  task automatic t_polarity();
    int h;
    wr(4'hC, 32'h13);
    sync_start(); measure(10, h); check(h == 7, "R7 inverted levels", h, 7);
    wr(4'hC, 32'h0B);
    sync_start(); measure(10, h); check(h == 3, "R7 normal levels restored", h, 3);
  endtask

  task automatic t_extremes();
    int h;
    wr(4'h8, 12); sync_start(); measure(20, h); check(h == 20, "R6 duty above period", h, 20);
    wr(4'h8, 10); sync_start(); measure(20, h); check(h == 20, "R6 duty equal period", h, 20);
    wr(4'h8, 0);  sync_start(); measure(20, h); check(h == 0, "R6 duty zero", h, 0);
    wr(4'h8, 3);  sync_start();
  endtask

  task automatic t_nopartial();
    int h;
    sync_start();
    wr(4'h8, 7);
    measure(8, h); check(h == 1, "R8 running period keeps old duty", h, 1);
    sync_start(); measure(10, h); check(h == 7, "R8 new duty next period", h, 7);
  endtask

  task automatic t_lock();
    int h;
    logic [31:0] v;
    wr(4'hC, 32'h4B);
    wr(4'h4, 6); wr(4'h8, 5); wr(4'hC, 32'h53);
    rd(4'h4, v); check(v == 6, "R11 staged period readable", v, 6);
    rd(4'h8, v); check(v == 5, "R11 staged duty readable", v, 5);
    sync_start(); measure(10, h); check(h == 7, "R9 locked waveform unchanged", h, 7);
    rd(4'h0, v); check(v == 0, "R9 locked period length", v, 0);
    measure(10, h); check(h == 7, "R9 still unchanged", h, 7);
    wr(4'hC, 32'h13);
    sync_start(); measure(6, h); check(h == 1, "R10 unlock commits all", h, 1);
    rd(4'h0, v); check(v == 0, "R10 new period length", v, 0);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    wr(4'hC, 32'h12);
    repeat (2) @(negedge clk); #1;
    rd(4'h0, v); check(v == 0, "R3 counter cleared on disable", v, 0);
    check(pwm == 1'b1, "R3 idle level on disable", pwm, 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #3; t_reset();
    #20; rst_n = 1'b1;
    t_reset();
    t_regs();
    t_basic();
    t_counter();
    t_polarity();
    t_extremes();
    t_nopartial();
    t_lock();
    t_disable();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule